// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit canonical virtual address into a physical address. It reads one 8-byte entry per level from a radix tree of four 512-entry tables held in memory. A root-pointer input gives the base of the top-level table. For each access the walker first checks that the address is canonical. It then reads the four levels in turn over a request/response memory port, with one request outstanding at a time. The walk ends with either the physical address of a 4 KiB page or a fault code. When a walk faults, the virtual address that caused it is latched into a fault-address output.

The walker also merges the permissions of all four levels. Write permission and user permission must be granted at every level, so one level that denies either is enough to refuse it. No-execute is set if any level sets it. The merged permissions are compared with the kind of access requested, which is read, write or instruction fetch, and with whether the access comes from user mode. The caching hints for each table read travel with the request. For the first read they come from the root pointer. For each later read they come from the entry that pointed to that table.

Top module: `ptw_walker`

## Requirements
- R1: The entry read at walk step k (k = 0 for the top table) is at byte address {table base, index, 3'b000}. The index is virtual address bits 47:39, 38:30, 29:21 and 20:12 for k = 0, 1, 2 and 3.
- R2: The first table base is root pointer bits 51:12. Root bits 63:52 have no effect on the request address.
- R3: mem_req_wt and mem_req_nc carry root bits 3 and 4 on the first read. On each later read they carry bits 3 and 4 of the entry read just before it.
- R4: If bits 63:48 of a request are not all equal to bit 47, done is raised on the cycle after acceptance with fault_code 3. No memory request is issued.
- R5: An entry whose bit 0 is clear ends the walk with fault_code 1. No further reads follow it.
- R6: An entry read at step 1 or step 2 with bit 7 set ends the walk with fault_code 4. Bit 7 is ignored at steps 0 and 3.
- R7: A walk that completes without fault raises done and resp_ok with fault_code 0. resp_paddr is then {leaf entry bits 51:12, virtual address bits 11:0}.
- R8: A write (req_kind 2'b01) faults with fault_code 2 when bit 1 is clear in any of the four entries. Reads (2'b00) do not check bit 1.
- R9: A user access (req_user = 1) faults with fault_code 2 when bit 2 is clear in any entry.
- R10: An instruction fetch (req_kind 2'b10) faults with fault_code 2 when bit 63 is set in any entry. Reads and writes ignore bit 63.
- R11: On every fault, fault_vaddr takes the request's virtual address. It keeps that value through later walks that do not fault.
- R12: req_ready is high only while idle, so a request is accepted only then. mem_req_valid is a one-cycle pulse, at most one per step, and the next one comes only after a response. done lasts exactly one cycle.
- R13: After reset, req_ready = 1, done = 0, mem_req_valid = 0 and fault_vaddr = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 64 | Virtual address to translate |
| req_kind | input | 2 | 00 read, 01 write, 10 instruction fetch |
| req_user | input | 1 | Access made from user mode |
| root_ptr | input | 64 | Root pointer: base in 51:12, caching hints in 3 and 4 |
| mem_req_valid | output | 1 | Entry read request (one-cycle pulse) |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_req_wt | output | 1 | Writethrough hint for the table being read |
| mem_req_nc | output | 1 | Uncacheable hint for the table being read |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| done | output | 1 | Walk finished (one cycle) |
| resp_ok | output | 1 | Walk finished without fault |
| resp_paddr | output | PA_W | Translated physical address |
| fault_code | output | 3 | 0 none, 1 not present, 2 protection, 3 non-canonical, 4 large page |
| fault_vaddr | output | 64 | Virtual address of the most recent fault |

## Verification
The checker watches timing and handshake rules on every cycle:
- A request never appears while the walker is idle, and request pulses never come back to back without a response between them.
- done drops after one cycle, and resp_ok agrees with a zero fault code.
- A non-canonical request faults on the next cycle without touching memory.
- The fault address and the page offset match the virtual address of the accepted request.

Only the bench scenarios can show the rest:
- The index slicing and base chaining at each step, and the per-step caching hints.
- How present, large-page, write, user and no-execute bits from different levels combine.
- That fault_vaddr keeps its value across walks that succeed.

// File: rtl/ptw_pkg.sv
// Shared types for the page table walker.
// Assumes 8-byte entries whose flag bits sit at the fixed positions below.
package ptw_pkg;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_WALK,
        WS_DONE,
        WS_FAULT
    } walk_st_t;

    typedef enum logic [2:0] {
        FC_NONE     = 3'd0,
        FC_ABSENT   = 3'd1,
        FC_PROT     = 3'd2,
        FC_NONCANON = 3'd3,
        FC_BIGPAGE  = 3'd4
    } fault_t;

    typedef enum logic [1:0] {
        AK_READ  = 2'd0,
        AK_WRITE = 2'd1,
        AK_FETCH = 2'd2
    } acc_kind_t;

    localparam int ENT_PRESENT = 0;
    localparam int ENT_WRITE   = 1;
    localparam int ENT_USER    = 2;
    localparam int ENT_WT      = 3;
    localparam int ENT_NC      = 4;
    localparam int ENT_SIZE    = 7;
    localparam int ENT_NOEXEC  = 63;

endpackage

// File: rtl/ptw_canon_chk.sv
// Canonical-form test: the upper address bits, together with the top
// implemented bit, must be all zeros or all ones.
// Assumes hi holds bits 63 down to VA_W-1 of the virtual address.
module ptw_canon_chk #(
    parameter int HI_W = 17
) (
    input  logic [HI_W-1:0] hi,
    output logic            canonical
);
    // All bits equal means the address is canonical.
    always_comb canonical = (&hi) | ~(|hi);
endmodule

// File: rtl/ptw_idx_sel.sv
// Picks the table index for the current walk step out of the virtual
// page number. Step 0 selects the most significant group.
// Assumes vpn holds LEVELS groups of IDX_W bits, top group first.
module ptw_idx_sel #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int LVL_W  = 2
) (
    input  logic [LEVELS*IDX_W-1:0] vpn,
    input  logic [LVL_W-1:0]        lvl,
    output logic [IDX_W-1:0]        idx
);
    logic [IDX_W-1:0] slice [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = vpn[IDX_W*(LEVELS-1-g) +: IDX_W];
    end

    // Step-indexed selection of the slice.
    always_comb idx = slice[lvl];
endmodule

// File: rtl/ptw_perm_acc.sv
// Accumulates permissions over the levels of one walk. Write and user
// are ANDed, no-execute is ORed. The outputs already include the entry
// currently on the response bus.
// Assumes start and absorb never occur in the same cycle.
module ptw_perm_acc (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic absorb,
    input  logic ent_wr,
    input  logic ent_us,
    input  logic ent_nx,
    output logic wr_all,
    output logic us_all,
    output logic nx_any
);
    logic wr_q, us_q, nx_q;

    // Reset to fully permissive at the start of a walk, fold in each entry.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            wr_q <= 1'b1;
            us_q <= 1'b1;
            nx_q <= 1'b0;
        end else if (absorb) begin
            wr_q <= wr_q & ent_wr;
            us_q <= us_q & ent_us;
            nx_q <= nx_q | ent_nx;
        end
    end

    // Merged view including the entry presented this cycle.
    always_comb begin
        wr_all = wr_q & ent_wr;
        us_all = us_q & ent_us;
        nx_any = nx_q | ent_nx;
    end
endmodule

// File: rtl/ptw_walker.sv
// Four-level page table walker for 4 KiB pages.
// Accepts one translation while idle. It checks that the address is
// canonical, then reads one entry per level with a single outstanding
// request, and reports done for one cycle with a physical address or a
// fault code. The faulting virtual address is held until the next fault.
// Assumes memory returns exactly one response per request, at any
// latency of zero or more cycles.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int PA_W   = 52,
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [63:0]     req_vaddr,
    input  logic [1:0]      req_kind,
    input  logic            req_user,
    input  logic [63:0]     root_ptr,
    output logic            mem_req_valid,
    output logic [PA_W-1:0] mem_req_addr,
    output logic            mem_req_wt,
    output logic            mem_req_nc,
    input  logic            mem_rsp_valid,
    input  logic [63:0]     mem_rsp_data,
    output logic            done,
    output logic            resp_ok,
    output logic [PA_W-1:0] resp_paddr,
    output logic [2:0]      fault_code,
    output logic [63:0]     fault_vaddr
);
    localparam int BASE_W = PA_W - OFF_W;
    localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int ENT_SH = OFF_W - IDX_W;
    localparam int VPN_W  = LEVELS * IDX_W;
    localparam int HI_W   = 64 - VA_W + 1;
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_st_t         state_q;
    logic [LVL_W-1:0] lvl_q;
    logic             issued_q;
    logic [63:0]      vaddr_q;
    acc_kind_t        kind_q;
    logic             user_q;
    logic [BASE_W-1:0] base_q;
    logic             wt_q, nc_q;
    logic [PA_W-1:0]  paddr_q;
    fault_t           code_q;
    logic [63:0]      fva_q;

    logic             canonical;
    logic [IDX_W-1:0] idx;
    logic             wr_all, us_all, nx_any;
    logic             accept, absorb, prot_hit, mid_lvl, last_lvl;

    ptw_canon_chk #(.HI_W(HI_W)) u_canon (
        .hi        (req_vaddr[63:VA_W-1]),
        .canonical (canonical)
    );

    ptw_idx_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_idx (
        .vpn (vaddr_q[OFF_W +: VPN_W]),
        .lvl (lvl_q),
        .idx (idx)
    );

    ptw_perm_acc u_perm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .absorb (absorb),
        .ent_wr (mem_rsp_data[ENT_WRITE]),
        .ent_us (mem_rsp_data[ENT_USER]),
        .ent_nx (mem_rsp_data[ENT_NOEXEC]),
        .wr_all (wr_all),
        .us_all (us_all),
        .nx_any (nx_any)
    );

    // Handshake and step qualifiers.
    always_comb begin
        accept   = req_valid && (state_q == WS_IDLE);
        absorb   = (state_q == WS_WALK) && mem_rsp_valid && mem_rsp_data[ENT_PRESENT];
        last_lvl = (lvl_q == LAST_LVL);
        mid_lvl  = (lvl_q != '0) && !last_lvl;
        prot_hit = ((kind_q == AK_WRITE) && !wr_all)
                 || (user_q && !us_all)
                 || ((kind_q == AK_FETCH) && nx_any);
    end

    // Port outputs decoded from the walk state.
    always_comb begin
        req_ready     = (state_q == WS_IDLE);
        mem_req_valid = (state_q == WS_WALK) && !issued_q;
        mem_req_addr  = {base_q, idx, {ENT_SH{1'b0}}};
        mem_req_wt    = wt_q;
        mem_req_nc    = nc_q;
        done          = (state_q == WS_DONE) || (state_q == WS_FAULT);
        resp_ok       = (state_q == WS_DONE);
        resp_paddr    = paddr_q;
        fault_code    = code_q;
        fault_vaddr   = fva_q;
    end

    // Walk sequencer: accept, step through the levels, report the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= WS_IDLE;
            lvl_q    <= '0;
            issued_q <= 1'b0;
            vaddr_q  <= '0;
            kind_q   <= AK_READ;
            user_q   <= 1'b0;
            base_q   <= '0;
            wt_q     <= 1'b0;
            nc_q     <= 1'b0;
            paddr_q  <= '0;
            code_q   <= FC_NONE;
            fva_q    <= '0;
        end else begin
            case (state_q)
                WS_IDLE: begin
                    if (accept) begin
                        vaddr_q <= req_vaddr;
                        kind_q  <= acc_kind_t'(req_kind);
                        user_q  <= req_user;
                        if (!canonical) begin
                            state_q <= WS_FAULT;
                            code_q  <= FC_NONCANON;
                            fva_q   <= req_vaddr;
                            paddr_q <= '0;
                        end else begin
                            state_q  <= WS_WALK;
                            lvl_q    <= '0;
                            issued_q <= 1'b0;
                            base_q   <= root_ptr[PA_W-1:OFF_W];
                            wt_q     <= root_ptr[ENT_WT];
                            nc_q     <= root_ptr[ENT_NC];
                        end
                    end
                end
                WS_WALK: begin
                    if (mem_req_valid) begin
                        issued_q <= 1'b1;
                    end
                    if (mem_rsp_valid) begin
                        issued_q <= 1'b0;
                        if (!mem_rsp_data[ENT_PRESENT]) begin
                            state_q <= WS_FAULT;
                            code_q  <= FC_ABSENT;
                            fva_q   <= vaddr_q;
                            paddr_q <= '0;
                        end else if (mid_lvl && mem_rsp_data[ENT_SIZE]) begin
                            state_q <= WS_FAULT;
                            code_q  <= FC_BIGPAGE;
                            fva_q   <= vaddr_q;
                            paddr_q <= '0;
                        end else if (last_lvl) begin
                            if (prot_hit) begin
                                state_q <= WS_FAULT;
                                code_q  <= FC_PROT;
                                fva_q   <= vaddr_q;
                                paddr_q <= '0;
                            end else begin
                                state_q <= WS_DONE;
                                code_q  <= FC_NONE;
                                paddr_q <= {mem_rsp_data[PA_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
                            end
                        end else begin
                            lvl_q  <= lvl_q + 1'b1;
                            base_q <= mem_rsp_data[PA_W-1:OFF_W];
                            wt_q   <= mem_rsp_data[ENT_WT];
                            nc_q   <= mem_rsp_data[ENT_NC];
                        end
                    end
                end
                default: begin
                    state_q <= WS_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/ptw_walker_chk.sv
// Property checker for ptw_walker. It sees only the top-level ports and
// keeps its own copy of the accepted virtual address.
module ptw_walker_chk #(
    parameter int VA_W = 48,
    parameter int PA_W = 52
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [63:0]     req_vaddr,
    input logic            mem_req_valid,
    input logic            mem_rsp_valid,
    input logic            done,
    input logic            resp_ok,
    input logic [PA_W-1:0] resp_paddr,
    input logic [2:0]      fault_code,
    input logic [63:0]     fault_vaddr
);
    logic [63:0]     va_seen;
    logic [64-VA_W:0] hi;
    logic            noncanon;

    // Capture the address of each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) va_seen <= '0;
        else if (req_valid && req_ready) va_seen <= req_vaddr;
    end

    // Independent canonical test on the request port.
    always_comb begin
        hi       = req_vaddr[63:VA_W-1];
        noncanon = !((&hi) || !(|hi));
    end

    p_noncanon_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && noncanon) |=> (done && !resp_ok && fault_code == 3'd3 && !mem_req_valid));

    p_ok_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && resp_ok) |-> (resp_paddr[11:0] == va_seen[11:0]));

    p_ok_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (resp_ok == (fault_code == 3'd0)));

    p_fault_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !resp_ok) |-> (fault_vaddr == va_seen));

    p_busy_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    p_single_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> !mem_req_valid);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind ptw_walker ptw_walker_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
    localparam int PA_W = 52;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [63:0]     req_vaddr = '0;
    logic [1:0]      req_kind = 2'd0;
    logic            req_user = 1'b0;
    logic [63:0]     root_ptr = '0;
    logic            mem_req_valid;
    logic [PA_W-1:0] mem_req_addr;
    logic            mem_req_wt, mem_req_nc;
    logic            mem_rsp_valid = 1'b0;
    logic [63:0]     mem_rsp_data = '0;
    logic            done, resp_ok;
    logic [PA_W-1:0] resp_paddr;
    logic [2:0]      fault_code;
    logic [63:0]     fault_vaddr;

    always #2.5 clk = ~clk;

    ptw_walker u0 (.*);

    int n_run = 0;
    int n_fail = 0;
    int lat = 1;
    int reads = 0;
    logic [63:0] cur_va = '0;
    logic [63:0] last_fva = '0;
    logic [3:0] e_pres, e_wr, e_us, e_nx, e_ps, e_wt, e_nc;
    logic       root_wt, root_nc;
    localparam logic [39:0] LEAF = 40'hABCDE12345;

    function automatic logic [39:0] tbase(int l);
        return 40'h9_0000_0000 + 40'(l + 1) * 40'h0_1357_9;
    endfunction

    function automatic logic [63:0] entry(int l);
        logic [39:0] nb;
        nb = (l < 3) ? tbase(l + 1) : LEAF;
        return {e_nx[l], 11'h0, nb, 4'h0, e_ps[l], 2'b00,
                e_nc[l], e_wt[l], e_us[l], e_wr[l], e_pres[l]};
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic set_open();
        e_pres = 4'hF; e_wr = 4'hF; e_us = 4'hF;
        e_nx = 4'h0; e_ps = 4'h0; e_wt = 4'h5; e_nc = 4'hA;
        root_wt = 1'b1; root_nc = 1'b0;
    endtask

    // Memory model: checks each entry request, answers after lat cycles.
    initial begin
        int pend;
        logic [63:0] pend_data;
        pend = 0;
        pend_data = '0;
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) mem_rsp_valid = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pend_data;
                end
            end
            if (mem_req_valid) begin
                if (reads < 4) begin
                    logic [51:0] ea;
                    logic exp_wt, exp_nc;
                    ea = {tbase(reads), cur_va[39 - 9*reads +: 9], 3'b000};
                    chk(mem_req_addr == ea, "R1 R2 entry address", 64'(mem_req_addr), 64'(ea));
                    exp_wt = (reads == 0) ? root_wt : e_wt[reads-1];
                    exp_nc = (reads == 0) ? root_nc : e_nc[reads-1];
                    chk(mem_req_wt == exp_wt && mem_req_nc == exp_nc, "R3 cache hints",
                        {62'd0, mem_req_nc, mem_req_wt}, {62'd0, exp_nc, exp_wt});
                    pend = lat;
                    pend_data = entry(reads);
                end else begin
                    chk(1'b0, "R12 extra read", 64'(reads), 64'd4);
                end
                reads++;
            end
        end
    end

    // One translation with expected results computed from the flag setup.
    task automatic run(logic [63:0] va, logic [1:0] kind, logic user, string tag);
        logic canon, wr, us, nx;
        logic [2:0] ecode;
        int ereads, cyc;
        logic [51:0] epa;
        root_ptr = {12'hFFF, tbase(0), 7'h00, root_nc, root_wt, 3'b000};
        lat = 1 + (n_run % 3);
        @(negedge clk);
        cur_va = va; reads = 0;
        req_vaddr = va; req_kind = kind; req_user = user; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R12 busy after accept", 64'(req_ready), 64'd0);
        cyc = 0;
        while (!done && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 300) chk(1'b0, "walk timeout", 64'(cyc), 64'd300);
        canon = (va[63:47] == '0) || (va[63:47] == '1);
        ecode = 3'd0; ereads = 4; wr = 1; us = 1; nx = 0;
        epa = {LEAF, va[11:0]};
        if (!canon) begin
            ecode = 3'd3; ereads = 0;
            chk(cyc == 0, "R4 fault latency", 64'(cyc), 64'd0);
        end else begin
            for (int l = 0; l < 4; l++) begin
                if (ecode == 3'd0) begin
                    if (!e_pres[l]) begin ecode = 3'd1; ereads = l + 1; end
                    else if ((l == 1 || l == 2) && e_ps[l]) begin ecode = 3'd4; ereads = l + 1; end
                    wr &= e_wr[l]; us &= e_us[l]; nx |= e_nx[l];
                end
            end
            if (ecode == 3'd0 && ((kind == 2'd1 && !wr) || (user && !us) || (kind == 2'd2 && nx)))
                ecode = 3'd2;
        end
        if (ecode != 3'd0) last_fva = va;
        chk(done && fault_code == ecode, tag, 64'(fault_code), 64'(ecode));
        chk(resp_ok == (ecode == 3'd0), tag, 64'(resp_ok), 64'(ecode == 3'd0));
        if (ecode == 3'd0) chk(resp_paddr == epa, "R7 paddr", 64'(resp_paddr), 64'(epa));
        chk(fault_vaddr == last_fva, "R11 fault address", fault_vaddr, last_fva);
        chk(reads == ereads, "R5 R12 read count", 64'(reads), 64'(ereads));
        @(negedge clk);
        chk(!done && req_ready, "R12 done one cycle", 64'(done), 64'd0);
    endtask

    function automatic logic [63:0] sx(logic [47:0] v);
        return {{16{v[47]}}, v};
    endfunction

    initial begin
        set_open();
        repeat (3) @(negedge clk);
        chk(req_ready && !done && !mem_req_valid && fault_vaddr == '0, "R13 reset state",
            {fault_vaddr[60:0], mem_req_valid, done, req_ready}, 64'd1);
        rst_n = 1'b1;

        // R7 R3: successful walks with varied addresses and hint patterns
        for (int i = 0; i < 16; i++) begin
            set_open();
            e_wt = 4'(i); e_nc = ~4'(i);
            root_wt = i[0]; root_nc = i[1];
            run(sx(48'(i) * 48'h1234_5678_9ABD + 48'h0F0F), 2'(i % 3), i[2], "R7 success");
        end
        set_open();
        run(64'h0000_7FFF_FFFF_FFFF, 2'd0, 1'b0, "R4 R7 top low-half");
        run(64'hFFFF_8000_0000_0000, 2'd0, 1'b0, "R4 R7 bottom high-half");

        // R5: absent entry at each level
        for (int l = 0; l < 4; l++) begin
            set_open();
            e_pres[l] = 1'b0;
            run(sx(48'h5A5A_1234_5678) + 64'(l), 2'd0, 1'b0, "R5 not present");
            set_open();
            run(sx(48'h1111_2222_3333), 2'd1, 1'b0, "R11 success keeps fault address");
        end

        // R6: size bit at each level
        for (int l = 0; l < 4; l++) begin
            set_open();
            e_ps[l] = 1'b1;
            run(sx(48'h8123_4567_89AB) + 64'(l * 8), 2'd0, 1'b0, "R6 large page");
        end

        // R8 R9: write and user permission sweep over all level combinations
        for (int w = 0; w < 16; w++) begin
            for (int u = 0; u < 16; u++) begin
                for (int k = 0; k < 3; k++) begin
                    for (int us = 0; us < 2; us++) begin
                        set_open();
                        e_wr = 4'(w); e_us = 4'(u);
                        run(sx(48'(w * 977 + u * 131 + k) << 12 | 48'h3C5), 2'(k), us[0], "R8 R9 permission");
                    end
                end
            end
        end

        // R10: no-execute sweep
        for (int n = 0; n < 16; n++) begin
            for (int k = 0; k < 3; k++) begin
                set_open();
                e_nx = 4'(n);
                run(sx(48'hC000_0000_0000 + 48'(n * 4099 + k)), 2'(k), 1'b0, "R10 no-execute");
            end
        end

        // R4: non-canonical forms
        set_open();
        run(64'h0001_0000_0000_0000, 2'd0, 1'b0, "R4 noncanonical");
        run(64'hFFFF_7FFF_FFFF_F000, 2'd1, 1'b0, "R4 noncanonical");
        run(64'h8000_0000_0000_1234, 2'd2, 1'b1, "R4 noncanonical");
        run(64'h0000_8000_0000_0000, 2'd0, 1'b0, "R4 noncanonical");
        run(sx(48'h0000_0040_2000), 2'd0, 1'b0, "R11 success after noncanonical");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #(160000 * 5);
        n_run++;
        n_fail++;
        $display("FAIL watchdog act=%0d exp=%0d", n_run, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule